// File: doc/BRIEF.md
# Signed/Unsigned Integer Divide-Modulo Unit

This block executes the divide and modulo instructions of a compact packet-filter style instruction set. One opcode byte and the 16-bit offset field of the instruction come in with the operands. The offset picks signed or unsigned arithmetic for the same operation code. The instruction class picks 32-bit or 64-bit width, and both widths share one datapath. The second operand is either a register value or a 32-bit immediate that is sign-extended to 64 bits.

The host pulses `start` while the unit is idle. The unit then computes the result with a restoring shift-subtract loop that takes one cycle per result bit. The host sees `busy` while the work runs. A single-cycle `done` pulse carries the result and is also the write-back strobe. An encoding the unit cannot execute is refused at once: it raises a one-cycle `illegal` flag and gives no write-back. Division by zero does not trap. It returns a fixed, defined result.

Top module: `divmod_unit`

## Requirements
- R1: The opcode byte splits into an operation code in bits 7:4, a source select in bit 3 and a class in bits 2:0. Operation code 0x3 divides and 0x9 takes the modulo. Class 3'b100 runs in 32-bit mode and class 3'b111 runs in 64-bit mode.
- R2: Offset 0 gives unsigned operation and offset 1 gives signed operation, for the same operation code.
- R3: Source bit 1 takes the divisor from `src_val`. Source bit 0 takes it from `imm`, sign-extended from 32 to 64 bits.
- R4: In 32-bit mode only bits 31:0 of both operands matter, and the result has bits 63:32 at zero.
- R5: A signed quotient truncates toward zero, and a signed remainder has the sign of the dividend. The most negative value divided by -1 gives that same most negative value, with remainder 0.
- R6: With a zero divisor, a divide returns 0 and a modulo returns the dividend unchanged. In 32-bit mode that dividend is zero-extended.
- R7: An offset other than 0 or 1, an operation code other than 0x3/0x9, or a class other than 3'b100/3'b111 makes `illegal` high for exactly the one cycle after the start edge. The unit then does not go busy and gives no `done`.
- R8: An accepted start holds `busy` high for N+1 cycles, where N is 32 or 64. `done` then pulses for one cycle, the first cycle after `busy` falls, and `result` is valid during that cycle.
- R9: A start while `busy` is high is ignored and does not change the result of the operation in flight.
- R10: After reset `busy`, `done` and `illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opcode | input | 8 | Operation code, source select, class |
| offset | input | 16 | Signedness selector |
| dst_val | input | 64 | Dividend register value |
| src_val | input | 64 | Divisor register value |
| imm | input | 32 | Immediate divisor, sign-extended |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| illegal | output | 1 | One-cycle refused-encoding flag |
| result | output | 64 | Quotient or remainder |

## Verification
The assertions assume that `start` is a plain pulse. They also assume that the operand inputs only matter on the edge where the unit is idle, so nothing is checked against operand changes during a run. The stimulus raises `start` for one cycle and holds the operands steady through that edge. It waits for the unit to return to idle before the next instruction, except in the deliberate start-while-busy case. The operands cover every sign pairing, zero divisors, the overflow pairing and garbage in the upper halves of the 32-bit operands.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

    localparam int IMM_W = 32;

    localparam logic [3:0]  OPC_DIV  = 4'h3;
    localparam logic [3:0]  OPC_MOD  = 4'h9;
    localparam logic [2:0]  CLS_W32  = 3'b100;
    localparam logic [2:0]  CLS_W64  = 3'b111;
    localparam logic [15:0] OFF_UNS  = 16'd0;
    localparam logic [15:0] OFF_SGN  = 16'd1;

    typedef struct packed {
        logic legal;
        logic is_mod;
        logic is_signed;
        logic is32;
        logic use_reg;
    } dm_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } dm_state_t;

    function automatic dm_ctrl_t dm_decode(input logic [7:0] opc, input logic [15:0] off);
        dm_ctrl_t c;
        logic op_ok, cls_ok, off_ok;
        op_ok       = (opc[7:4] == OPC_DIV) || (opc[7:4] == OPC_MOD);
        cls_ok      = (opc[2:0] == CLS_W32) || (opc[2:0] == CLS_W64);
        off_ok      = (off == OFF_UNS) || (off == OFF_SGN);
        c.legal     = op_ok && cls_ok && off_ok;
        c.is_mod    = (opc[7:4] == OPC_MOD);
        c.is_signed = (off == OFF_SGN);
        c.is32      = (opc[2:0] == CLS_W32);
        c.use_reg   = opc[3];
        return c;
    endfunction

endpackage

// File: rtl/divmod_decode.sv
module divmod_decode
    import divmod_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [15:0] offset,
    output dm_ctrl_t    ctrl
);
    always_comb begin
        ctrl = dm_decode(opcode, offset);
    end
endmodule

// File: rtl/divmod_prep.sv
module divmod_prep
    import divmod_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  dm_ctrl_t         ctrl,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  dvd_aligned,
    output logic [XLEN-1:0]  dvs_mag,
    output logic [XLEN-1:0]  dvd_keep,
    output logic             neg_quo,
    output logic             neg_rem,
    output logic             dvs_zero
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] keep_mask, imm_ext;
    logic [XLEN-1:0] a_raw, b_raw, a_neg, b_neg, a_mag;
    logic            a_sign, b_sign;

    always_comb begin
        keep_mask = ctrl.is32 ? {{HALF{1'b0}}, {HALF{1'b1}}} : {XLEN{1'b1}};
        imm_ext   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        a_raw     = dst_val & keep_mask;
        b_raw     = (ctrl.use_reg ? src_val : imm_ext) & keep_mask;
        a_sign    = ctrl.is_signed & (ctrl.is32 ? a_raw[HALF-1] : a_raw[XLEN-1]);
        b_sign    = ctrl.is_signed & (ctrl.is32 ? b_raw[HALF-1] : b_raw[XLEN-1]);
        a_neg     = (XLEN'(0) - a_raw) & keep_mask;
        b_neg     = (XLEN'(0) - b_raw) & keep_mask;
        a_mag     = a_sign ? a_neg : a_raw;
        dvs_mag   = b_sign ? b_neg : b_raw;
        // left-align narrow dividend so iteration always starts at the top bit
        dvd_aligned = ctrl.is32 ? (a_mag << HALF) : a_mag;
        dvd_keep  = a_raw;
        dvs_zero  = (b_raw == '0);
        neg_quo   = a_sign ^ b_sign;
        neg_rem   = a_sign;
    end
endmodule

// File: rtl/divmod_iter.sv
module divmod_iter #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] dvd_in,
    input  logic [XLEN-1:0] dvs_in,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    logic [XLEN-1:0] q_r, d_r;
    logic [XLEN:0]   r_r;
    logic [XLEN:0]   shifted, diff;

    always_comb begin
        shifted = {r_r[XLEN-1:0], q_r[XLEN-1]};
        diff    = shifted - {1'b0, d_r};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
            r_r <= '0;
            d_r <= '0;
        end else if (load) begin
            q_r <= dvd_in;
            r_r <= '0;
            d_r <= dvs_in;
        end else if (step) begin
            if (!diff[XLEN]) begin
                r_r <= diff;
                q_r <= {q_r[XLEN-2:0], 1'b1};
            end else begin
                r_r <= shifted;
                q_r <= {q_r[XLEN-2:0], 1'b0};
            end
        end
    end

    assign quo = q_r;
    assign rem = r_r[XLEN-1:0];
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
    import divmod_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [15:0]      offset,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic [XLEN-1:0]  result
);
    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN + 1);

    dm_ctrl_t        dec;
    dm_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [XLEN-1:0] dvd_aligned, dvs_mag, dvd_keep, quo, rem;
    logic            neg_quo, neg_rem, dvs_zero;
    logic            accept, last_step;

    logic            run_is32, run_mod, run_nq, run_nr, run_zero;
    logic [XLEN-1:0] run_keep;
    logic [XLEN-1:0] pick, signed_val, fin_val, out_mask;

    divmod_decode u_dec (
        .opcode (opcode),
        .offset (offset),
        .ctrl   (dec)
    );

    divmod_prep #(.XLEN(XLEN)) u_prep (
        .ctrl        (dec),
        .dst_val     (dst_val),
        .src_val     (src_val),
        .imm         (imm),
        .dvd_aligned (dvd_aligned),
        .dvs_mag     (dvs_mag),
        .dvd_keep    (dvd_keep),
        .neg_quo     (neg_quo),
        .neg_rem     (neg_rem),
        .dvs_zero    (dvs_zero)
    );

    assign accept = (state == ST_IDLE) && start && dec.legal;

    divmod_iter #(.XLEN(XLEN)) u_iter (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (state == ST_RUN),
        .dvd_in (dvd_aligned),
        .dvs_in (dvs_mag),
        .quo    (quo),
        .rem    (rem)
    );

    always_comb begin
        last_step  = (cnt == (run_is32 ? CNT_W'(HALF - 1) : CNT_W'(XLEN - 1)));
        out_mask   = run_is32 ? {{HALF{1'b0}}, {HALF{1'b1}}} : {XLEN{1'b1}};
        pick       = run_mod ? rem : quo;
        signed_val = (run_mod ? run_nr : run_nq) ? (XLEN'(0) - pick) : pick;
        fin_val    = (run_zero ? (run_mod ? run_keep : '0) : signed_val) & out_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            done     <= 1'b0;
            illegal  <= 1'b0;
            result   <= '0;
            run_is32 <= 1'b0;
            run_mod  <= 1'b0;
            run_nq   <= 1'b0;
            run_nr   <= 1'b0;
            run_zero <= 1'b0;
            run_keep <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (dec.legal) begin
                            state    <= ST_RUN;
                            cnt      <= '0;
                            run_is32 <= dec.is32;
                            run_mod  <= dec.is_mod;
                            run_nq   <= neg_quo;
                            run_nr   <= neg_rem;
                            run_zero <= dvs_zero;
                            run_keep <= dvd_keep;
                        end else begin
                            illegal <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (last_step) state <= ST_FIN;
                end
                ST_FIN: begin
                    result <= fin_val;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/divmod_checker.sv
module divmod_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            mode32,
    input logic            zero_div,
    input logic            is_mod,
    input logic [XLEN-1:0] result
);
    localparam int HALF = XLEN / 2;

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r7_illegal_refused: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!busy && !done && $past(start) && !$past(busy)));

    a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (done && mode32) |-> (result[XLEN-1:HALF] == '0));

    a_r6_zero_quotient: assert property (@(posedge clk) disable iff (rst)
        (done && zero_div && !is_mod) |-> (result == '0));
endmodule

bind divmod_unit divmod_checker #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .mode32   (run_is32),
    .zero_div (run_zero),
    .is_mod   (run_mod),
    .result   (result)
);

// File: tb/divmod_unit_test.sv
`timescale 1ns/1ps
module divmod_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] offset = '0;
    logic [63:0] dst_val = '0, src_val = '0;
    logic [31:0] imm = '0;
    logic        busy, done, illegal;
    logic [63:0] result;

    int checks = 0, fails = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // reference model state
    bit          m_busy = 0, m_done = 0, m_ill = 0;
    int          m_left = 0;
    logic [63:0] m_res = '0;

    always #2.5 clk = ~clk;

    divmod_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .offset(offset),
        .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .busy(busy), .done(done), .illegal(illegal), .result(result)
    );

    function automatic logic [63:0] ref_calc(logic [7:0] opc, logic [15:0] off,
                                             logic [63:0] a, logic [63:0] s, logic [31:0] im);
        logic [63:0] b;
        logic        is_mod, sg;
        logic [31:0] a32, b32, q32, m32;
        logic [63:0] q64, m64;
        int          sa, sb;
        longint      la, lb;
        b      = opc[3] ? s : {{32{im[31]}}, im};
        is_mod = (opc[7:4] == 4'h9);
        sg     = (off == 16'd1);
        if (opc[2:0] == 3'b100) begin
            a32 = a[31:0]; b32 = b[31:0];
            if (b32 == 0) begin q32 = 0; m32 = a32; end
            else if (sg) begin
                sa = a32; sb = b32;
                if (sb == -1) begin q32 = 32'd0 - a32; m32 = 0; end
                else begin q32 = sa / sb; m32 = sa % sb; end
            end else begin q32 = a32 / b32; m32 = a32 % b32; end
            return {32'd0, is_mod ? m32 : q32};
        end
        if (b == 0) begin q64 = 0; m64 = a; end
        else if (sg) begin
            la = a; lb = b;
            if (lb == -1) begin q64 = 64'd0 - a; m64 = 0; end
            else begin q64 = la / lb; m64 = la % lb; end
        end else begin q64 = a / b; m64 = a % b; end
        return is_mod ? m64 : q64;
    endfunction

    function automatic bit legal_enc(logic [7:0] opc, logic [15:0] off);
        return ((opc[7:4] == 4'h3) || (opc[7:4] == 4'h9)) &&
               ((opc[2:0] == 3'b100) || (opc[2:0] == 3'b111)) &&
               (off <= 16'd1);
    endfunction

    // behavioural cycle model
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_ill = 0; m_left = 0; m_res = '0;
        end else begin
            m_done = 0; m_ill = 0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin m_busy = 0; m_done = 1; end
            end else if (start) begin
                if (!legal_enc(opcode, offset)) m_ill = 1;
                else begin
                    m_busy = 1;
                    m_left = (opcode[2:0] == 3'b100) ? 33 : 65;
                    m_res  = ref_calc(opcode, offset, dst_val, src_val, imm);
                end
            end
        end
    end

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(busy == m_busy, "R8", "busy", 64'(busy), 64'(m_busy));
            check(done == m_done, "R8", "done", 64'(done), 64'(m_done));
            check(illegal == m_ill, "R7", "illegal", 64'(illegal), 64'(m_ill));
            if (m_done) check(result == m_res, cur_tag, "result", result, m_res);
        end
    end

    task automatic issue(string tag, logic [7:0] opc, logic [15:0] off,
                         logic [63:0] a, logic [63:0] s, logic [31:0] im);
        @(negedge clk);
        cur_tag = tag;
        opcode = opc; offset = off; dst_val = a; src_val = s; imm = im;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy || m_done || m_ill);
    endtask

    task automatic run(string tag, logic [7:0] opc, logic [15:0] off,
                       logic [63:0] a, logic [63:0] s, logic [31:0] im);
        issue(tag, opc, off, a, s, im);
        wait_idle();
    endtask

    // opcode helpers: {op, src, class}
    localparam logic [7:0] DIV64R = 8'h3F, MOD64R = 8'h9F, DIV64I = 8'h37, MOD64I = 8'h97;
    localparam logic [7:0] DIV32R = 8'h3C, MOD32R = 8'h9C, DIV32I = 8'h34, MOD32I = 8'h94;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !illegal, "R10", "flags", {61'd0, busy, done, illegal}, 64'd0);
        check(result == 64'd0, "R10", "result", result, 64'd0);

        run("R1", DIV64R, 16'd0, 64'd1000, 64'd7, 32'd0);
        run("R1", MOD64R, 16'd0, 64'd1000, 64'd7, 32'd0);
        run("R2", DIV64R, 16'd0, -64'sd1000, 64'd7, 32'd0);
        run("R2", DIV64R, 16'd1, -64'sd1000, 64'd7, 32'd0);
        run("R5", MOD64R, 16'd1, -64'sd1000, 64'd7, 32'd0);
        run("R5", MOD64R, 16'd1, 64'd1000, -64'sd7, 32'd0);
        run("R5", DIV64R, 16'd1, -64'sd1000, -64'sd7, 32'd0);
        run("R3", DIV64I, 16'd1, 64'd100, 64'd5, -32'sd3);
        run("R3", DIV64I, 16'd0, 64'd100, 64'd5, -32'sd3);
        run("R3", MOD64I, 16'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'h8000_0000);
        run("R4", DIV32R, 16'd0, 64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0007, 32'd0);
        run("R4", DIV32R, 16'd1, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, 32'd0);
        run("R4", MOD32I, 16'd1, 64'h0000_0001_FFFF_FF9C, 64'd0, 32'd7);
        run("R6", DIV64R, 16'd0, 64'd55, 64'd0, 32'd0);
        run("R6", MOD64R, 16'd1, -64'sd55, 64'd0, 32'd0);
        run("R6", MOD32R, 16'd0, 64'hAAAA_AAAA_8000_0001, 64'hFFFF_FFFF_0000_0000, 32'd0);
        run("R6", DIV32I, 16'd1, 64'd9, 64'd0, 32'd0);
        run("R5", DIV64R, 16'd1, 64'h8000_0000_0000_0000, -64'sd1, 32'd0);
        run("R5", MOD64R, 16'd1, 64'h8000_0000_0000_0000, -64'sd1, 32'd0);
        run("R5", DIV32I, 16'd1, 64'h0000_0000_8000_0000, 64'd0, 32'hFFFF_FFFF);
        run("R7", DIV64R, 16'd2, 64'd10, 64'd2, 32'd0);
        run("R7", MOD32R, 16'hFFFF, 64'd10, 64'd2, 32'd0);
        run("R7", 8'h4F, 16'd0, 64'd10, 64'd2, 32'd0);
        run("R7", 8'h3D, 16'd0, 64'd10, 64'd2, 32'd0);
        // R9: a second start during the run must be ignored
        issue("R9", DIV64R, 16'd0, 64'd900, 64'd30, 32'd0);
        repeat (4) @(negedge clk);
        opcode = MOD32R; dst_val = 64'd77; src_val = 64'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        // back-to-back operations right after done
        issue("R8", DIV32R, 16'd0, 64'd81, 64'd9, 32'd0);
        wait_idle();
        issue("R8", MOD64I, 16'd1, -64'sd81, 64'd0, 32'd10);
        wait_idle();
        for (int i = 0; i < 40; i++) begin
            logic [7:0] opc;
            opc = {($urandom % 2) ? 4'h9 : 4'h3, 1'($urandom), ($urandom % 2) ? 3'b100 : 3'b111};
            run("R2", opc, 16'($urandom % 2), {$urandom, $urandom},
                ($urandom % 4 == 0) ? 64'(($urandom % 9)) : {$urandom, $urandom}, $urandom);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule